// File: doc/BRIEF.md
# Stereo Silence Run Detector

This block watches a two-channel serial audio stream and raises a flag for each channel once that channel has carried nothing but zero samples for a long, unbroken run of sample frames. A small deserializer inside the block follows the bit clock and the word clock. It marks where each channel's word ends and records whether any one bit was set in that word. A saturating run counter for each channel then decides the flag.

The block has two word-clock inputs. One is the normal sample word clock. The other is the word clock of an external interpolation filter. A mode input selects which of them delimits the words. All serial inputs are oversampled by a single system clock through a synchronizer. Each channel flag drives an output pin and also a status bit intended for register readback. The status bit always equals its pin.

Top module: `audio_zero_watch`

## Requirements
- R1: The left flag (`zero_l`) goes to 1 when the word end that completes 1024 consecutive all-zero left words is processed, and it is still 0 after 1023 such words. The left word is the one sent while the selected word clock is low, and it ends on that clock's rising edge.
- R2: The right flag (`zero_r`) follows the same 1024-word rule on its own counter. The right word is the one sent while the selected word clock is high, and it ends on that clock's falling edge.
- R3: A channel word that holds any 1 bit clears that channel's counter and flag when the word ends. The other channel's flag is left unchanged.
- R4: Once a channel's count reaches 1024 it holds there, so further zero words keep the flag at 1 and the count does not wrap.
- R5: With `ext_mode`=0, only `wclk` edges end words and `wclk_ext` is ignored. With `ext_mode`=1, only `wclk_ext` edges end words and `wclk` is ignored.
- R6: `stat_zero_l` always equals `zero_l`, and `stat_zero_r` always equals `zero_r`. The value 1 means zero run detected and 0 means not zero.
- R7: While `rst` is high at a clock edge, both counters and both flags clear to 0.
- R8: Serial data is taken only at rising edges of `bclk`. A 1 on `sdata` that appears after a rising edge and is gone before the next rising edge does not count as a nonzero bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| wclk | input | 1 | Normal sample word clock (low = left, high = right) |
| wclk_ext | input | 1 | External-filter word clock (same channel polarity) |
| sdata | input | 1 | Serial audio data |
| ext_mode | input | 1 | 1 selects `wclk_ext` as the word delimiter, 0 selects `wclk` |
| zero_l | output | 1 | Left zero-run flag pin, active high |
| zero_r | output | 1 | Right zero-run flag pin, active high |
| stat_zero_l | output | 1 | Left zero-run status bit for readback |
| stat_zero_r | output | 1 | Right zero-run status bit for readback |

## Verification
The first stimulus is an unbroken run of all-zero frames, checked at word 1023 and at word 1024. It separates a correct threshold from an off-by-one threshold, and it shows that both channels count in step. Next, a single set bit is sent at the LSB of the left word and, separately, at the MSB of the right word. This shows that one bit in any position clears only its own channel, and a continued zero run shows that the count saturates and does not wrap. Frames carrying nonzero data are also sent on the word clock that is not selected, in each mode. In both cases the flags must keep their value. Data pulses that occur only between bit-clock rising edges must likewise leave the flags unchanged, which shows that sampling is tied to the rising edge and is not level sensitive.

// File: rtl/azw_pkg.sv
package azw_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // One completed channel word as seen by the run counters
  typedef struct packed {
    logic  valid;
    chan_e chan;
    logic  nz;
  } word_evt_t;

  // Bit positions inside the synchronized input vector
  localparam int IN_BCLK  = 0;
  localparam int IN_WCLK  = 1;
  localparam int IN_WCLKE = 2;
  localparam int IN_DATA  = 3;
  localparam int IN_MODE  = 4;
  localparam int IN_W     = 5;

endpackage

// File: rtl/azw_in_sync.sv
module azw_in_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/azw_deser.sv
module azw_deser
  import azw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bclk_s,
  input  logic      wclk_s,
  input  logic      wclke_s,
  input  logic      data_s,
  input  logic      mode_s,
  output word_evt_t evt
);

  logic bclk_q, wclk_q, wclke_q;
  logic acc;

  logic bit_rise;
  logic std_rise, std_fall, ext_rise, ext_fall;
  logic word_rise, word_fall;

  assign bit_rise = bclk_s & ~bclk_q;
  assign std_rise = wclk_s & ~wclk_q;
  assign std_fall = ~wclk_s & wclk_q;
  assign ext_rise = wclke_s & ~wclke_q;
  assign ext_fall = ~wclke_s & wclke_q;

  // Edges are found per clock and then selected, so a mode change
  // between clocks of different level creates no false word end.
  assign word_rise = mode_s ? ext_rise : std_rise;
  assign word_fall = mode_s ? ext_fall : std_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b0;
      wclk_q  <= 1'b0;
      wclke_q <= 1'b0;
    end else begin
      bclk_q  <= bclk_s;
      wclk_q  <= wclk_s;
      wclke_q <= wclke_s;
    end
  end

  // Sticky OR of all bits taken during the current channel half
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= 1'b0;
    end else if (word_rise || word_fall) begin
      acc <= bit_rise & data_s;
    end else if (bit_rise) begin
      acc <= acc | data_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt <= '0;
    end else begin
      evt.valid <= word_rise | word_fall;
      evt.chan  <= word_rise ? CH_LEFT : CH_RIGHT;
      evt.nz    <= acc;
    end
  end

endmodule

// File: rtl/azw_run_count.sv
module azw_run_count #(
  parameter int RUN_LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic nz,
  output logic flag
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT    = CW'(RUN_LEN);
  localparam logic [CW-1:0] LIMIT_M1 = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (hit) begin
      if (nz) begin
        cnt  <= '0;
        flag <= 1'b0;
      end else if (cnt != LIMIT) begin
        cnt  <= cnt + 1'b1;
        flag <= (cnt == LIMIT_M1);
      end
    end
  end

endmodule

// File: rtl/audio_zero_watch.sv
module audio_zero_watch
  import azw_pkg::*;
#(
  parameter int RUN_LEN     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic wclk,
  input  logic wclk_ext,
  input  logic sdata,
  input  logic ext_mode,
  output logic zero_l,
  output logic zero_r,
  output logic stat_zero_l,
  output logic stat_zero_r
);

  logic [IN_W-1:0] raw_in, syn_in;
  word_evt_t       evt;
  logic [NUM_CH-1:0] zflag;

  assign raw_in[IN_BCLK]  = bclk;
  assign raw_in[IN_WCLK]  = wclk;
  assign raw_in[IN_WCLKE] = wclk_ext;
  assign raw_in[IN_DATA]  = sdata;
  assign raw_in[IN_MODE]  = ext_mode;

  azw_in_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (syn_in)
  );

  azw_deser u_deser (
    .clk     (clk),
    .rst     (rst),
    .bclk_s  (syn_in[IN_BCLK]),
    .wclk_s  (syn_in[IN_WCLK]),
    .wclke_s (syn_in[IN_WCLKE]),
    .data_s  (syn_in[IN_DATA]),
    .mode_s  (syn_in[IN_MODE]),
    .evt     (evt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hit;
    assign hit = evt.valid && (evt.chan == chan_e'(ch));
    azw_run_count #(.RUN_LEN(RUN_LEN)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .hit  (hit),
      .nz   (evt.nz),
      .flag (zflag[ch])
    );
  end

  // One register per channel feeds both the pin and the status bit
  assign zero_l      = zflag[CH_LEFT];
  assign zero_r      = zflag[CH_RIGHT];
  assign stat_zero_l = zflag[CH_LEFT];
  assign stat_zero_r = zflag[CH_RIGHT];

endmodule

// File: rtl/azw_chk.sv
module azw_chk #(
  parameter int RUN_LEN = 1024
) (
  input logic clk,
  input logic rst,
  input logic ev_valid,
  input logic ev_chan,
  input logic ev_nz,
  input logic zero_l,
  input logic zero_r
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LEN);

  logic [CW-1:0] ck_l, ck_r;
  logic hit_l, hit_r;

  assign hit_l = ev_valid && !ev_chan;
  assign hit_r = ev_valid && ev_chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_l <= '0;
      ck_r <= '0;
    end else begin
      if (hit_l) ck_l <= ev_nz ? '0 : ((ck_l == LIM) ? ck_l : ck_l + 1'b1);
      if (hit_r) ck_r <= ev_nz ? '0 : ((ck_r == LIM) ? ck_r : ck_r + 1'b1);
    end
  end

  // R1
  run_l_chk: assert property (@(posedge clk) disable iff (rst)
    zero_l == (ck_l == LIM));

  // R2
  run_r_chk: assert property (@(posedge clk) disable iff (rst)
    zero_r == (ck_r == LIM));

  // R3
  clear_l_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_l && ev_nz) |=> !zero_l);

  // R3
  clear_r_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_r && ev_nz) |=> !zero_r);

  // R4
  hold_l_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_l && !(hit_l && ev_nz)) |=> zero_l);

  // R4
  hold_r_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_r && !(hit_r && ev_nz)) |=> zero_r);

  // R7
  reset_chk: assert property (@(posedge clk)
    rst |=> (!zero_l && !zero_r));

endmodule

bind audio_zero_watch azw_chk #(.RUN_LEN(RUN_LEN)) u_azw_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_valid (evt.valid),
  .ev_chan  (evt.chan),
  .ev_nz    (evt.nz),
  .zero_l   (zero_l),
  .zero_r   (zero_r)
);

// File: tb/tb_audio_zero_watch.sv
module tb_audio_zero_watch;

  localparam int RUN = 1024;
  localparam int NB  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, wclk = 1'b0, wclk_ext = 1'b0, sdata = 1'b0, ext_mode = 1'b0;
  logic zero_l, zero_r, stat_zero_l, stat_zero_r;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  bit    qzl[$];
  bit    qzr[$];
  string qtag[$];

  int m_cnt_l = 0, m_cnt_r = 0;
  bit sel_ext = 1'b0;

  always #10 clk = ~clk;

  audio_zero_watch dut (
    .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .wclk_ext(wclk_ext),
    .sdata(sdata), .ext_mode(ext_mode), .zero_l(zero_l), .zero_r(zero_r),
    .stat_zero_l(stat_zero_l), .stat_zero_r(stat_zero_r)
  );

  task automatic push_exp(input string tag);
    qzl.push_back(m_cnt_l >= RUN);
    qzr.push_back(m_cnt_r >= RUN);
    qtag.push_back(tag);
  endtask

  task automatic send_bits(input logic [NB-1:0] pat, input bit glitch);
    for (int i = NB - 1; i >= 0; i--) begin
      @(negedge clk); sdata = pat[i]; bclk = 1'b0;
      repeat (2) @(negedge clk);
      bclk = 1'b1;
      if (glitch) begin
        @(negedge clk); sdata = 1'b1;
        @(negedge clk); sdata = 1'b0;
      end else begin
        repeat (2) @(negedge clk);
      end
    end
  endtask

  task automatic set_wc(input bit on_ext, input logic v);
    if (on_ext) wclk_ext = v; else wclk = v;
  endtask

  // One frame: left half (word clock low), right half (high), back low
  task automatic frame(input logic [NB-1:0] lp, input logic [NB-1:0] rp,
                       input bit on_ext, input bit glitch, input string tag);
    send_bits(lp, glitch);
    @(negedge clk); bclk = 1'b0; set_wc(on_ext, 1'b1);
    repeat (2) @(negedge clk);
    send_bits(rp, glitch);
    @(negedge clk); bclk = 1'b0; sdata = 1'b0; set_wc(on_ext, 1'b0);
    repeat (8) @(negedge clk);
    if (on_ext == sel_ext) begin
      m_cnt_l = (lp != '0) ? 0 : ((m_cnt_l < RUN) ? m_cnt_l + 1 : m_cnt_l);
      m_cnt_r = (rp != '0) ? 0 : ((m_cnt_r < RUN) ? m_cnt_r + 1 : m_cnt_r);
    end
    push_exp(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    m_cnt_l = 0; m_cnt_r = 0;
    repeat (2) @(negedge clk);
    push_exp(tag);
  endtask

  // Monitor: pops expected items and compares pins and status bits
  initial begin
    forever begin
      @(posedge clk); #5;
      while (qzl.size() > 0) begin
        bit el, er;
        string t;
        el = qzl.pop_front(); er = qzr.pop_front(); t = qtag.pop_front();
        total++;
        if (zero_l !== el || zero_r !== er) begin
          bad++;
          $display("FAIL %s: pins l=%b r=%b expected l=%b r=%b", t, zero_l, zero_r, el, er);
        end
        total++;
        if (stat_zero_l !== zero_l || stat_zero_r !== zero_r) begin
          bad++;
          $display("FAIL R6 (%s): status l=%b r=%b expected l=%b r=%b",
                   t, stat_zero_l, stat_zero_r, zero_l, zero_r);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset("R7 reset state");

    // R1 R2: 1023 zero frames keep flags low, the 1024th sets them
    for (int k = 0; k < RUN - 1; k++) frame('0, '0, 1'b0, 1'b0, "R1 R2 below run length");
    frame('0, '0, 1'b0, 1'b0, "R1 R2 run length reached");

    // R8: pulses between rising edges are not data
    for (int k = 0; k < 5; k++) frame('0, '0, 1'b0, 1'b1, "R8 off-edge pulses ignored");

    // R5: mode 0 ignores frames on the filter word clock
    for (int k = 0; k < 5; k++) frame('1, '1, 1'b1, 1'b0, "R5 ext clock ignored in mode 0");

    // R3: LSB set on left clears only left
    frame(4'b0001, '0, 1'b0, 1'b0, "R3 left clear");
    // R4: right saturates and holds
    for (int k = 0; k < 30; k++) frame('0, '0, 1'b0, 1'b0, "R4 saturated hold");
    // R3: MSB set on right clears only right
    frame('0, 4'b1000, 1'b0, 1'b0, "R3 right clear");

    do_reset("R7 mid-run reset");

    // R5: mode 1 counts on the filter word clock
    @(negedge clk); ext_mode = 1'b1; sel_ext = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < RUN - 1; k++) frame('0, '0, 1'b1, 1'b0, "R5 ext count below run");
    frame('0, '0, 1'b1, 1'b0, "R5 R1 R2 ext run reached");
    for (int k = 0; k < 5; k++) frame('1, '1, 1'b0, 1'b0, "R5 normal clock ignored in mode 1");
    frame(4'b0100, '0, 1'b1, 1'b0, "R3 left clear in mode 1");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule